// File: doc/BRIEF.md
# Processor Boot Sequencer

This block brings a stack processor from reset to its first method call without software help. Right after reset it gives the stack pointer its initial value. It then reads the processor number. A processor whose number is not zero goes to an idle park state and does nothing more. Processor zero sets its monitor count to one and opens a 32-bit word stream. It copies the program image from that stream into main memory through a plain write port.

The image begins with two header words. The first header word is the total image length in words, and it also becomes the heap pointer. The second header word is the method pointer. All further words are stored without being examined. Once the last counted word is stored, the block closes the stream and derives two more pointers, method pointer plus one and method pointer plus two. It then raises a single-cycle invoke strobe that carries the method pointer. After the strobe, a done flag stays high.

If the length in the header cannot describe a valid image, the block stops in an error state. A valid length is at least two words and at most the memory depth of 2^ADDR_W words. In the error state the error flag is set and the invoke strobe is never raised.

Top module: `boot_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pointer output, `mon_cnt`, `s_ready`, `mem_we`, `invoke`, `done` and `err` read zero after that edge.
- R2: The first step after reset loads `sp` with the parameter `SP_INIT`. This happens for every processor number.
- R3: When `cpu_id` is 0, `mon_cnt` reads 1 before `s_ready` is first raised.
- R4: When `cpu_id` is nonzero, the block parks. `s_ready`, `mem_we`, `invoke`, `done`, `err` and `mon_cnt` all stay 0, and only `sp` changes.
- R5: The first accepted word (index 0) is the image length and is copied to `heap_ptr`. The second accepted word (index 1) is copied to `meth_ptr`.
- R6: Accepted word number k is written at `mem_addr` = k with its data unchanged, for k from 0 to length−1. `s_ready` then drops, so any further offered words are neither accepted nor written.
- R7: Before `invoke` is raised, `ptr_p1` equals `meth_ptr`+1 and `ptr_p2` equals `meth_ptr`+2. While `invoke` is high, `invoke_mp` equals `meth_ptr`.
- R8: `invoke` is high for exactly one cycle per boot. `done` is low during that cycle, then rises in the next cycle and stays high until reset.
- R9: A length below 2 or above 2^ADDR_W causes an error. The header word is still written at address 0 and still copied to `heap_ptr`. After that, `s_ready` stays low, `err` stays high and `invoke` never rises.
- R10: A cycle with `s_valid` low writes nothing and does not advance the address. Idle gaps of any length between words leave the stored image unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_id | input | CPU_ID_W | Processor number; only 0 loads |
| s_data | input | DATA_W | Stream word |
| s_valid | input | 1 | Stream word present |
| s_ready | output | 1 | Block accepts a word this cycle |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| sp | output | DATA_W | Stack pointer |
| mon_cnt | output | MON_W | Monitor count |
| heap_ptr | output | DATA_W | Heap pointer (image length) |
| meth_ptr | output | DATA_W | Method pointer |
| ptr_p1 | output | DATA_W | Method pointer plus one |
| ptr_p2 | output | DATA_W | Method pointer plus two |
| invoke | output | 1 | One-cycle invoke request |
| invoke_mp | output | DATA_W | Method pointer carried with invoke |
| done | output | 1 | Boot finished |
| err | output | 1 | Invalid length seen |

## Verification
With a two-word image, the word that ends the load is also the word that captures the method pointer. The write of the last word, the method pointer capture and the close of the stream therefore all happen on the same edge. With a bad header, the length check and the first memory write happen on the same edge. The sweep provokes both cases with every length from 0 to one above the depth, and with idle gaps of several sizes. Each case is judged by the writes recorded in the bench, the pointers present during the invoke cycle, and the one-invoke count.

// File: rtl/boot_pkg.sv
// Package: shared state encoding of the boot sequencer.
// Assumes: nothing beyond SystemVerilog enums.
package boot_pkg;
    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_MON    = 3'd1,
        ST_LOAD   = 3'd2,
        ST_DERIV  = 3'd3,
        ST_INVOKE = 3'd4,
        ST_DONE   = 3'd5,
        ST_PARK   = 3'd6,
        ST_ERR    = 3'd7
    } boot_state_t;
endpackage

// File: rtl/boot_stream_cnt.sv
// Module: boot_stream_cnt
// Counts accepted stream words, which also gives the write address. It keeps
// the length from the header and reports the first word, the second word,
// the last word and a bad length.
// Assumes: hs is high only while the controller accepts words.
module boot_stream_cnt #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs,
    input  logic [DATA_W-1:0] s_data,
    output logic [ADDR_W-1:0] addr,
    output logic              hs_first,
    output logic              hs_second,
    output logic              hs_last,
    output logic              len_bad
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] len_q;
    logic [DATA_W-1:0] cnt_ext;

    assign cnt_ext = DATA_W'(cnt);
    assign addr    = cnt[ADDR_W-1:0];

    // Decode the position of the current word and check the header length.
    always_comb begin
        hs_first  = hs && (cnt == '0);
        hs_second = hs && (cnt == CNT_W'(1));
        hs_last   = hs && (cnt != '0) && (cnt_ext == len_q - DATA_W'(1));
        len_bad   = (s_data < DATA_W'(2)) || (s_data > DATA_W'(DEPTH));
    end

    // Advance the word count on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (hs) cnt <= cnt + CNT_W'(1);
    end

    // Keep the image length taken from the header word.
    always_ff @(posedge clk) begin
        if (!rst_n)        len_q <= '0;
        else if (hs_first) len_q <= s_data;
    end

    // R6
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && (cnt != '0)) |-> (cnt_ext < len_q));
endmodule

// File: rtl/boot_ptr_file.sv
// Module: boot_ptr_file
// Holds the runtime pointer registers and loads each one on the strobes
// that the controller and the counter give.
// Assumes: each load strobe lasts exactly one cycle.
module boot_ptr_file #(
    parameter int          DATA_W  = 32,
    parameter int          MON_W   = 8,
    parameter logic [31:0] SP_INIT = 32'h0000_0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_sp,
    input  logic              ld_mon,
    input  logic              hs_first,
    input  logic              hs_second,
    input  logic              ld_deriv,
    input  logic              invoke,
    input  logic [DATA_W-1:0] s_data,
    output logic [DATA_W-1:0] sp,
    output logic [MON_W-1:0]  mon_cnt,
    output logic [DATA_W-1:0] heap_ptr,
    output logic [DATA_W-1:0] meth_ptr,
    output logic [DATA_W-1:0] ptr_p1,
    output logic [DATA_W-1:0] ptr_p2
);
    // Stack pointer takes its start value in the first step after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     sp <= '0;
        else if (ld_sp) sp <= DATA_W'(SP_INIT);
    end

    // Monitor count is set to one before a load.
    always_ff @(posedge clk) begin
        if (!rst_n)      mon_cnt <= '0;
        else if (ld_mon) mon_cnt <= MON_W'(1);
    end

    // The two header words go to the heap and method pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            heap_ptr <= '0;
            meth_ptr <= '0;
        end else begin
            if (hs_first)  heap_ptr <= s_data;
            if (hs_second) meth_ptr <= s_data;
        end
    end

    // The derived pointers are computed once the image has been stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_p1 <= '0;
            ptr_p2 <= '0;
        end else if (ld_deriv) begin
            ptr_p1 <= meth_ptr + DATA_W'(1);
            ptr_p2 <= meth_ptr + DATA_W'(2);
        end
    end

    // R7
    deriv_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invoke |-> ((ptr_p1 == meth_ptr + DATA_W'(1)) && (ptr_p2 == meth_ptr + DATA_W'(2))));
endmodule

// File: rtl/boot_fsm.sv
// Module: boot_fsm
// Controls the boot order: initial stack pointer, processor check, monitor
// count, stream load, derived pointers, invoke, then done. A bad header
// sends it to the error state.
// Assumes: cpu_id is stable in the first cycle after reset.
module boot_fsm
    import boot_pkg::*;
#(
    parameter int CPU_ID_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_ID_W-1:0] cpu_id,
    input  logic                hs_first,
    input  logic                hs_last,
    input  logic                len_bad,
    output logic                s_ready,
    output logic                ld_sp,
    output logic                ld_mon,
    output logic                ld_deriv,
    output logic                invoke,
    output logic                done,
    output logic                err
);
    boot_state_t state, state_nx;

    // Choose the next step of the boot order.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT:   state_nx = (cpu_id == '0) ? ST_MON : ST_PARK;
            ST_MON:    state_nx = ST_LOAD;
            ST_LOAD: begin
                if (hs_first && len_bad) state_nx = ST_ERR;
                else if (hs_last)        state_nx = ST_DERIV;
            end
            ST_DERIV:  state_nx = ST_INVOKE;
            ST_INVOKE: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_DONE;
            ST_PARK:   state_nx = ST_PARK;
            ST_ERR:    state_nx = ST_ERR;
            default:   state_nx = ST_ERR;
        endcase
    end

    // Hold the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_nx;
    end

    // Decode the strobes and flags from the current step.
    always_comb begin
        ld_sp    = (state == ST_INIT);
        ld_mon   = (state == ST_MON);
        s_ready  = (state == ST_LOAD);
        ld_deriv = (state == ST_DERIV);
        invoke   = (state == ST_INVOKE);
        done     = (state == ST_DONE);
        err      = (state == ST_ERR);
    end

    // R8
    invoke_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invoke |=> (!invoke && done));
    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !s_ready && !invoke));
endmodule

// File: rtl/boot_sequencer.sv
// Module: boot_sequencer (top)
// Loads the program image from a valid/ready word stream into memory and
// sets the processor pointers. It then gives a one-cycle invoke request.
// Assumes: the memory accepts one write per cycle and needs no handshake.
module boot_sequencer #(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 10,
    parameter int          CPU_ID_W = 4,
    parameter int          MON_W    = 8,
    parameter logic [31:0] SP_INIT  = 32'h0000_0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_ID_W-1:0] cpu_id,
    input  logic [DATA_W-1:0]   s_data,
    input  logic                s_valid,
    output logic                s_ready,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic [DATA_W-1:0]   sp,
    output logic [MON_W-1:0]    mon_cnt,
    output logic [DATA_W-1:0]   heap_ptr,
    output logic [DATA_W-1:0]   meth_ptr,
    output logic [DATA_W-1:0]   ptr_p1,
    output logic [DATA_W-1:0]   ptr_p2,
    output logic                invoke,
    output logic [DATA_W-1:0]   invoke_mp,
    output logic                done,
    output logic                err
);
    logic hs, hs_first, hs_second, hs_last, len_bad;
    logic ld_sp, ld_mon, ld_deriv;

    // An accepted word is written straight through to memory.
    always_comb begin
        hs        = s_valid && s_ready;
        mem_we    = hs;
        mem_wdata = s_data;
        invoke_mp = meth_ptr;
    end

    boot_fsm #(.CPU_ID_W(CPU_ID_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id),
        .hs_first(hs_first), .hs_last(hs_last), .len_bad(len_bad),
        .s_ready(s_ready), .ld_sp(ld_sp), .ld_mon(ld_mon),
        .ld_deriv(ld_deriv), .invoke(invoke), .done(done), .err(err)
    );

    boot_stream_cnt #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .hs(hs), .s_data(s_data),
        .addr(mem_addr), .hs_first(hs_first), .hs_second(hs_second),
        .hs_last(hs_last), .len_bad(len_bad)
    );

    boot_ptr_file #(.DATA_W(DATA_W), .MON_W(MON_W), .SP_INIT(SP_INIT)) i_ptr (
        .clk(clk), .rst_n(rst_n), .ld_sp(ld_sp), .ld_mon(ld_mon),
        .hs_first(hs_first), .hs_second(hs_second), .ld_deriv(ld_deriv),
        .invoke(invoke), .s_data(s_data), .sp(sp), .mon_cnt(mon_cnt),
        .heap_ptr(heap_ptr), .meth_ptr(meth_ptr), .ptr_p1(ptr_p1), .ptr_p2(ptr_p2)
    );

    // R3
    mon_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (mon_cnt == MON_W'(1)));
    // R2
    sp_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (sp == DATA_W'(SP_INIT)));
endmodule

// File: tb/test_boot_sequencer.sv
// Bench: sweeps every header length from 0 to DEPTH+1 with several idle-gap
// patterns, plus nonzero processor numbers. Expected values are computed
// from the image pattern.
module test_boot_sequencer;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW    = 4;
    localparam int          DEPTH = 1 << AW;
    localparam logic [31:0] SPI   = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cpu_id = '0;
    logic [31:0] s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready, mem_we, invoke, done, err;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, sp, heap_ptr, meth_ptr, ptr_p1, ptr_p2, invoke_mp;
    logic [7:0]  mon_cnt;

    int n_chk = 0, n_fail = 0;
    int wr_count = 0, inv_count = 0;
    int cur_len = 0;
    bit inv_seen = 1'b0;
    logic [31:0] cur_mp = '0;

    boot_sequencer #(.DATA_W(32), .ADDR_W(AW), .CPU_ID_W(4), .MON_W(8), .SP_INIT(SPI))
    i_boot_sequencer (
        .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .s_data(s_data), .s_valid(s_valid),
        .s_ready(s_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .sp(sp), .mon_cnt(mon_cnt), .heap_ptr(heap_ptr), .meth_ptr(meth_ptr),
        .ptr_p1(ptr_p1), .ptr_p2(ptr_p2), .invoke(invoke), .invoke_mp(invoke_mp),
        .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mp_of(input int len);
        return 32'h0000_1000 + 32'(len * 7);
    endfunction

    function automatic logic [31:0] img(input int len, input int k);
        if (k == 0) return 32'(len);
        if (k == 1) return mp_of(len);
        return {16'(len), 16'(k)} ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (len %0d cpu %0d)", tag, act, exp, cur_len, cpu_id);
        end
    endtask

    // Monitor, sampled at the falling edge: records writes and invokes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                chk(32'(mem_addr) == 32'(wr_count), "R6 address", 32'(mem_addr), 32'(wr_count));
                chk(mem_wdata == img(cur_len, wr_count), "R6 data", mem_wdata, img(cur_len, wr_count));
                wr_count++;
            end
            if (invoke) begin
                inv_count++;
                chk(invoke_mp == cur_mp, "R7 invoke_mp", invoke_mp, cur_mp);
                chk(ptr_p1 == cur_mp + 1, "R7 ptr_p1", ptr_p1, cur_mp + 1);
                chk(ptr_p2 == cur_mp + 2, "R7 ptr_p2", ptr_p2, cur_mp + 2);
                chk(!done, "R8 done low at invoke", 32'(done), 0);
            end
            if (s_ready)
                chk(mon_cnt == 8'd1, "R3 mon before load", 32'(mon_cnt), 1);
            if (inv_seen)
                chk(done, "R8 done held", 32'(done), 1);
            if (invoke) inv_seen = 1'b1;
        end
    end

    task automatic do_reset(input logic [3:0] id);
        s_valid = 1'b0;
        rst_n   = 1'b0;
        cpu_id  = id;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        chk(sp == 0 && mon_cnt == 0 && !s_ready && !done && !err && !invoke && heap_ptr == 0,
            "R1 reset state", sp, 0);
        wr_count = 0; inv_count = 0; inv_seen = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Offer one word until it is taken or lim cycles pass; gap idles first.
    task automatic offer(input logic [31:0] w, input int gap, input int lim, output bit taken);
        bit acc;
        repeat (gap) begin @(posedge clk); #1; end
        s_valid = 1'b1;
        s_data  = w;
        taken   = 1'b0;
        for (int t = 0; t < lim; t++) begin
            @(negedge clk) acc = s_ready;
            @(posedge clk); #1;
            if (acc) begin taken = 1'b1; break; end
        end
        s_valid = 1'b0;
    endtask

    task automatic boot_case(input int len, input int gap);
        bit tk;
        bit bad;
        int words;
        bad    = (len < 2) || (len > DEPTH);
        cur_len = len;
        cur_mp  = mp_of(len);
        do_reset(4'd0);
        words = bad ? 1 : len;
        for (int k = 0; k < words; k++) begin
            offer(img(len, k), (gap != 0 && (k % 3) == 1) ? gap : 0, 40, tk);
            chk(tk, "R10 word accepted", 32'(k), 1);
        end
        offer(32'hDEAD_BEEF, 0, 8, tk);
        chk(!tk, "R6 extra word refused", 32'(tk), 0);
        @(negedge clk);
        chk(wr_count == words, "R6 write count", 32'(wr_count), 32'(words));
        chk(heap_ptr == 32'(len), "R5 heap_ptr", heap_ptr, 32'(len));
        chk(sp == SPI, "R2 sp", sp, SPI);
        chk(!s_ready, "R6 ready low after", 32'(s_ready), 0);
        if (bad) begin
            chk(err && !done, "R9 error flag", 32'(err), 1);
            chk(inv_count == 0, "R9 no invoke", 32'(inv_count), 0);
        end else begin
            chk(meth_ptr == cur_mp, "R5 meth_ptr", meth_ptr, cur_mp);
            chk(inv_count == 1, "R8 one invoke", 32'(inv_count), 1);
            chk(done && !err, "R8 done", 32'(done), 1);
        end
    endtask

    task automatic park_case(input logic [3:0] id);
        bit tk;
        cur_len = 5;
        cur_mp  = mp_of(5);
        do_reset(id);
        offer(img(5, 0), 0, 10, tk);
        chk(!tk, "R4 park refuses words", 32'(tk), 0);
        @(negedge clk);
        chk(wr_count == 0 && inv_count == 0, "R4 no writes or invoke", 32'(wr_count), 0);
        chk(mon_cnt == 0 && !done && !err, "R4 flags idle", 32'(mon_cnt), 0);
        chk(sp == SPI, "R2 sp on parked cpu", sp, SPI);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int g = 0; g < 3; g++)
            for (int len = 0; len <= DEPTH + 1; len++)
                boot_case(len, g);
        for (int id = 1; id < 4; id++)
            park_case(4'(id));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule